// File: doc/BRIEF.md
# Fault Polling and Power State Controller

This block supervises a multiphase core-voltage regulator. It walks the supply through its power states (off, soft-start, regulation, a recoverable tristate hold and a latched shutdown) and keeps a steady round-robin poll of the fault status of every active power stage over a request/response register-read port. Each stage reports a 2-bit fault status. A recoverable fault tristates the phase outputs until a full poll round comes back clean. A fatal fault, a bus error flagged by the serial link, or a poll that goes unanswered shuts the supply down until reset, which stands in for a power cycle.

During soft-start the block ramps a reference code from zero toward the 6-bit VID target, one LSB per programmable number of cycles. Power-good is raised only after the supply has been in regulation for one full poll round. The serial physical layer sits outside this block. It answers each request by raising `poll_valid_i` together with the addressed stage's status.

Top module: `pwr_supervisor`

## Requirements
- R1: While reset is asserted, and right after it, `state_o` is OFF (code 0), and `ref_o`, `pgood_o`, `drive_en_o` and `poll_req_o` are all 0. State codes are OFF=0, SOFTSTART=1, REGULATE=2, TRISTATE=3, LATCHED_OFF=4.
- R2: With `enable_i` high, OFF moves to SOFTSTART on the next edge. With `enable_i` low, every state except LATCHED_OFF moves to OFF on the next edge, and this takes priority over any fault.
- R3: `ref_o` is 0 when SOFTSTART is entered and steps by one toward `vid_i` every `ramp_div_i` edges (a value of 0 counts as 1). SOFTSTART moves to REGULATE on the edge after `ref_o` equals `vid_i`, so a target of V with divider D reaches REGULATE V*D+1 edges after entry.
- R4: Polling runs only in SOFTSTART, REGULATE and TRISTATE. It keeps one read outstanding, holds `poll_req_o` and `poll_addr_o` until `poll_valid_i`, and cycles the address 0,1,…,N-1,0. N is `nphase_i`, with 0 treated as 1 and values above 6 treated as 6.
- R5: A response with status bit 0 set, received in SOFTSTART or REGULATE, moves the block to TRISTATE on the edge that takes the response.
- R6: TRISTATE returns to SOFTSTART, with the ramp restarted from 0, at the end of the first complete poll round in which no stage reported bit 0. While any stage still reports bit 0, the block stays in TRISTATE.
- R7: A response with status bit 1 set, or `bus_err_i` high, in a polling state moves the block to LATCHED_OFF on the next edge.
- R8: A request left unanswered for 64 cycles counts as a bus error. The block is still polling after 63 waiting edges and is in LATCHED_OFF after the 64th.
- R9: LATCHED_OFF ignores `enable_i` and every poll input, and only reset clears it.
- R10: `pgood_o` rises on the edge of the second poll-round completion (a response from stage N-1) seen in REGULATE. It falls on the same edge that leaves REGULATE.
- R11: `drive_en_o` is high exactly in SOFTSTART and REGULATE.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset (power cycle) |
| enable_i | input | 1 | Output enable request |
| vid_i | input | 6 | Regulation target code |
| nphase_i | input | 3 | Number of active power stages |
| ramp_div_i | input | 8 | Cycles per soft-start reference step |
| poll_req_o | output | 1 | Fault register read request |
| poll_addr_o | output | 3 | Stage being polled |
| poll_valid_i | input | 1 | Read response valid |
| poll_data_i | input | 2 | Fault status: bit 0 recoverable, bit 1 fatal |
| bus_err_i | input | 1 | Serial bus error flag |
| state_o | output | 3 | Current power state code |
| drive_en_o | output | 1 | Phase drivers enabled |
| pgood_o | output | 1 | Power good |
| ref_o | output | 6 | Soft-start / regulation reference code |

## Verification
State changes caused by a poll response, a bus error or an enable change appear one edge after the cycle that presents them. The ramp reaches V after V*D edges from SOFTSTART entry and REGULATE follows one edge later. Power-good follows the edge of the second round completion in REGULATE, and the timeout takes effect on the 64th waiting edge. The bench samples one time unit after each falling edge, counts edges from a known rising edge of `poll_req_o` or from the entry edge, and checks both the edge before and the edge of each transition.

// File: rtl/sup_pkg.sv
package sup_pkg;
  typedef enum logic [2:0] {
    ST_OFF   = 3'd0,
    ST_SOFT  = 3'd1,
    ST_REG   = 3'd2,
    ST_TRI   = 3'd3,
    ST_LATCH = 3'd4
  } sup_state_e;
endpackage

// File: rtl/sup_poller.sv
module sup_poller #(
  parameter int N_STAGES = 6,
  parameter int TMO      = 64,
  parameter int AW       = $clog2(N_STAGES + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          run_i,
  input  logic [AW-1:0] nphase_i,
  input  logic          poll_valid_i,
  input  logic [1:0]    poll_data_i,
  output logic          poll_req_o,
  output logic [AW-1:0] poll_addr_o,
  output logic          rec_o,
  output logic          fatal_o,
  output logic          tmo_o,
  output logic          round_o,
  output logic          clean_o
);
  localparam int CW = $clog2(TMO + 1);

  logic          req_q, dirty_q;
  logic [AW-1:0] addr_q, last;
  logic [CW-1:0] cnt_q;
  logic          acc;

  always_comb begin
    if (nphase_i == '0)                 last = '0;
    else if (nphase_i > AW'(N_STAGES))  last = AW'(N_STAGES - 1);
    else                                last = nphase_i - AW'(1);
  end

  assign acc     = req_q & poll_valid_i;
  assign rec_o   = acc & poll_data_i[0];
  assign fatal_o = acc & poll_data_i[1];
  assign round_o = acc & (addr_q >= last);
  assign clean_o = round_o & ~dirty_q & ~poll_data_i[0];
  assign tmo_o   = req_q & ~poll_valid_i & (cnt_q == CW'(TMO - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      req_q <= 1'b0; addr_q <= '0; cnt_q <= '0; dirty_q <= 1'b0;
    end else if (!run_i) begin
      req_q <= 1'b0; addr_q <= '0; cnt_q <= '0; dirty_q <= 1'b0;
    end else if (!req_q) begin
      req_q <= 1'b1;
      cnt_q <= '0;
    end else if (acc) begin
      req_q   <= 1'b0;
      addr_q  <= (addr_q >= last) ? '0 : addr_q + AW'(1);
      dirty_q <= round_o ? 1'b0 : (dirty_q | poll_data_i[0]);
    end else if (cnt_q != CW'(TMO - 1)) begin
      cnt_q <= cnt_q + CW'(1);
    end
  end

  assign poll_req_o  = req_q;
  assign poll_addr_o = addr_q;

  assert_req_hold_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && poll_req_o && !poll_valid_i) |=> (poll_req_o && $stable(poll_addr_o)));
  assert_addr_range_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    poll_addr_o < AW'(N_STAGES));
  assert_idle_stop_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_i |=> !poll_req_o);
endmodule

// File: rtl/sup_ramp.sv
module sup_ramp #(
  parameter int VW   = 6,
  parameter int DIVW = 8
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            act_i,
  input  logic [VW-1:0]   target_i,
  input  logic [DIVW-1:0] div_i,
  output logic [VW-1:0]   ref_o,
  output logic            at_tgt_o
);
  logic [VW-1:0]   ref_q;
  logic [DIVW-1:0] cnt_q, lim;

  assign lim = (div_i == '0) ? '0 : div_i - DIVW'(1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ref_q <= '0; cnt_q <= '0;
    end else if (!act_i) begin
      ref_q <= '0; cnt_q <= '0;
    end else if (cnt_q >= lim) begin
      cnt_q <= '0;
      if (ref_q < target_i)      ref_q <= ref_q + VW'(1);
      else if (ref_q > target_i) ref_q <= ref_q - VW'(1);
    end else begin
      cnt_q <= cnt_q + DIVW'(1);
    end
  end

  assign ref_o    = ref_q;
  assign at_tgt_o = (ref_q == target_i);

  assert_ref_step_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    act_i |=> (ref_o == $past(ref_o) || ref_o == $past(ref_o) + VW'(1) ||
               ref_o == $past(ref_o) - VW'(1)));
  assert_ref_idle_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !act_i |=> (ref_o == '0));
endmodule

// File: rtl/pwr_supervisor.sv
module pwr_supervisor
  import sup_pkg::*;
#(
  parameter int N_STAGES = 6,
  parameter int VID_W    = 6,
  parameter int DIV_W    = 8,
  parameter int TMO      = 64,
  parameter int AW       = $clog2(N_STAGES + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             enable_i,
  input  logic [VID_W-1:0] vid_i,
  input  logic [AW-1:0]    nphase_i,
  input  logic [DIV_W-1:0] ramp_div_i,
  output logic             poll_req_o,
  output logic [AW-1:0]    poll_addr_o,
  input  logic             poll_valid_i,
  input  logic [1:0]       poll_data_i,
  input  logic             bus_err_i,
  output logic [2:0]       state_o,
  output logic             drive_en_o,
  output logic             pgood_o,
  output logic [VID_W-1:0] ref_o
);
  sup_state_e state_q, state_d;
  logic run, ramp_act, at_tgt;
  logic rec, fatal, tmo, round, clean;
  logic arm_q, pg_q;

  assign run      = (state_q == ST_SOFT) || (state_q == ST_REG) || (state_q == ST_TRI);
  assign ramp_act = (state_q == ST_SOFT) || (state_q == ST_REG);

  sup_poller #(.N_STAGES(N_STAGES), .TMO(TMO), .AW(AW)) u_poll (
    .clk_i, .rst_ni, .run_i(run), .nphase_i,
    .poll_valid_i, .poll_data_i, .poll_req_o, .poll_addr_o,
    .rec_o(rec), .fatal_o(fatal), .tmo_o(tmo), .round_o(round), .clean_o(clean)
  );

  sup_ramp #(.VW(VID_W), .DIVW(DIV_W)) u_ramp (
    .clk_i, .rst_ni, .act_i(ramp_act), .target_i(vid_i), .div_i(ramp_div_i),
    .ref_o, .at_tgt_o(at_tgt)
  );

  always_comb begin
    state_d = state_q;
    if (state_q == ST_LATCH)            state_d = ST_LATCH;
    else if (!enable_i)                 state_d = ST_OFF;
    else if (state_q == ST_OFF)         state_d = ST_SOFT;
    else if (fatal || tmo || bus_err_i) state_d = ST_LATCH;
    else begin
      case (state_q)
        ST_SOFT: if (rec) state_d = ST_TRI; else if (at_tgt) state_d = ST_REG;
        ST_REG:  if (rec) state_d = ST_TRI;
        ST_TRI:  if (clean) state_d = ST_SOFT;
        default: state_d = ST_OFF;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_OFF;
    else         state_q <= state_d;
  end

  // power good needs one full round inside REGULATE
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      arm_q <= 1'b0; pg_q <= 1'b0;
    end else if (state_q != ST_REG) begin
      arm_q <= 1'b0; pg_q <= 1'b0;
    end else if (round) begin
      if (arm_q) pg_q <= 1'b1;
      else       arm_q <= 1'b1;
    end
  end

  assign state_o    = state_q;
  assign drive_en_o = ramp_act;
  assign pgood_o    = pg_q && (state_q == ST_REG);

  assert_latch_sticky_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_LATCH) |=> (state_q == ST_LATCH));
  assert_bus_err_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (enable_i && run && bus_err_i) |=> (state_q == ST_LATCH));
  assert_timeout_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (enable_i && run && tmo) |=> (state_q == ST_LATCH));
  assert_pgood_reg_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pgood_o |-> (state_q == ST_REG));
  assert_disable_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!enable_i && state_q != ST_LATCH) |=> (state_q == ST_OFF));
  assert_tri_entry_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((state_q == ST_SOFT || state_q == ST_REG) && enable_i && rec && !fatal && !bus_err_i)
      |=> (state_q == ST_TRI));
endmodule

// File: tb/tb_pwr_supervisor.sv
module tb_pwr_supervisor;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic en = 1'b0;
  logic [5:0] vid = '0;
  logic [2:0] nph = 3'd1;
  logic [7:0] div = 8'd1;
  logic req, valid = 1'b0, berr = 1'b0;
  logic [2:0] addr;
  logic [1:0] data = '0;
  logic [2:0] st;
  logic drv, pg;
  logic [5:0] rf;

  int total = 0, bad = 0, cyc = 0;
  bit auto_rsp = 1'b1;
  logic [1:0] fault [6];
  int exp_addr = 0, rnd = 0, dly = 0, last_addr = -1;

  localparam logic [2:0] S_OFF = 3'd0, S_SOFT = 3'd1, S_REG = 3'd2, S_TRI = 3'd3, S_LAT = 3'd4;
  // vid, divider, phase count
  localparam logic [16:0] VEC [0:4] = '{
    {6'd5, 8'd3, 3'd3}, {6'd0, 8'd2, 3'd6}, {6'd2, 8'd0, 3'd1},
    {6'd9, 8'd1, 3'd0}, {6'd4, 8'd2, 3'd7}};

  pwr_supervisor dut (
    .clk_i(clk), .rst_ni(rst_n), .enable_i(en), .vid_i(vid), .nphase_i(nph),
    .ramp_div_i(div), .poll_req_o(req), .poll_addr_o(addr), .poll_valid_i(valid),
    .poll_data_i(data), .bus_err_i(berr), .state_o(st), .drive_en_o(drv),
    .pgood_o(pg), .ref_o(rf));

  always #5 clk = ~clk;

  function automatic int neff();
    if (nph == 0) return 1;
    if (nph > 6) return 6;
    return int'(nph);
  endfunction

  task automatic chk(input bit ok, input string r, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", r, act, exp);
    end
  endtask

  task automatic step(); @(negedge clk); #1; endtask

  // responder: answers each request two cycles late
  always @(negedge clk) begin
    if (st != S_REG) rnd = 0;
    if (st == S_OFF || st == S_LAT) exp_addr = 0;
    if (!auto_rsp || !rst_n || !req || !(st == S_SOFT || st == S_REG || st == S_TRI)) begin
      valid = 1'b0; dly = 0;
    end else if (valid) begin
      valid = 1'b0;
    end else if (dly < 2) begin
      dly++;
    end else begin
      valid = 1'b1; data = fault[addr]; dly = 0;
      chk(int'(addr) == exp_addr, "R4 poll address", int'(addr), exp_addr);
      last_addr = int'(addr);
      exp_addr = (exp_addr + 1) % neff();
      if (st == S_REG && int'(addr) == neff() - 1) rnd++;
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      bad++; total++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic do_reset();
    rst_n = 1'b0; en = 1'b0; berr = 1'b0; auto_rsp = 1'b1;
    for (int i = 0; i < 6; i++) fault[i] = 2'd0;
    step(); step();
    rst_n = 1'b1;
    step();
  endtask

  task automatic wait_state(input logic [2:0] s, input int lim);
    for (int i = 0; i < lim && st != s; i++) step();
  endtask

  task automatic wait_leave(input logic [2:0] s, input int lim);
    for (int i = 0; i < lim && st == s; i++) step();
  endtask

  task automatic go_reg(input logic [5:0] v, input logic [7:0] d, input logic [2:0] n);
    do_reset();
    vid = v; div = d; nph = n; en = 1'b1;
    wait_state(S_REG, 2000);
  endtask

  initial begin
    for (int i = 0; i < 6; i++) fault[i] = 2'd0;
    step();
    chk(st == S_OFF && rf == 0 && !pg && !drv && !req, "R1 in reset", int'(st), 0);
    do_reset();
    chk(st == S_OFF && rf == 0 && !pg && !drv && !req, "R1 after reset", int'(st), 0);
    step();
    chk(st == S_OFF && !req, "R2 stays off while disabled", int'(st), 0);

    // table walk: ramp timing, addressing, power good
    for (int k = 0; k < 5; k++) begin
      int v, d;
      do_reset();
      vid = VEC[k][16:11]; div = VEC[k][10:3]; nph = VEC[k][2:0];
      v = int'(vid); d = (div == 0) ? 1 : int'(div);
      en = 1'b1;
      step();
      chk(st == S_SOFT && drv, "R2 off to softstart", int'(st), 1);
      chk(rf == 0, "R3 ramp starts at zero", int'(rf), 0);
      if (v > 0) begin
        for (int i = 0; i < v * d - 1; i++) step();
        chk(rf == v - 1 && st == S_SOFT, "R3 one step short", int'(rf), v - 1);
        step();
        chk(rf == v && st == S_SOFT, "R3 target reached", int'(rf), v);
      end
      step();
      chk(st == S_REG, "R3 enter regulate", int'(st), 2);
      chk(drv, "R11 drive in regulate", int'(drv), 1);
      for (int i = 0; i < 500 && rnd < 1; i++) step();
      chk(!pg, "R10 no power good after first round", int'(pg), 0);
      for (int i = 0; i < 500 && rnd < 2; i++) step();
      chk(!pg, "R10 power good not before second round edge", int'(pg), 0);
      step();
      chk(pg, "R10 power good after second round", int'(pg), 1);
    end

    // disable from regulate
    en = 1'b0;
    step();
    chk(st == S_OFF && !pg && !drv, "R2 disable to off, R10 pgood drops", int'(st), 0);

    // disable during softstart
    do_reset();
    vid = 6'd20; div = 8'd4; nph = 3'd2; en = 1'b1;
    for (int i = 0; i < 10; i++) step();
    en = 1'b0;
    step();
    chk(st == S_OFF, "R2 disable from softstart", int'(st), 0);

    // recoverable fault
    go_reg(6'd3, 8'd1, 3'd3);
    for (int i = 0; i < 30; i++) step();
    fault[1] = 2'd1;
    wait_leave(S_REG, 200);
    chk(st == S_TRI && last_addr == 1, "R5 recoverable to tristate", int'(st), 3);
    chk(!drv && !pg, "R11 no drive in tristate", int'(drv), 0);
    for (int i = 0; i < 60; i++) step();
    chk(st == S_TRI, "R6 hold while fault persists", int'(st), 3);
    fault[1] = 2'd0;
    wait_leave(S_TRI, 200);
    chk(st == S_SOFT && rf == 0, "R6 clean round back to softstart", int'(st), 1);
    wait_state(S_REG, 200);
    chk(st == S_REG, "R6 regulates again", int'(st), 2);

    // fatal fault during softstart
    do_reset();
    vid = 6'd40; div = 8'd8; nph = 3'd4; fault[2] = 2'd2; en = 1'b1;
    step();
    wait_leave(S_SOFT, 500);
    chk(st == S_LAT && last_addr == 2, "R7 fatal latches", int'(st), 4);
    chk(!drv && !pg, "R11 no drive latched", int'(drv), 0);
    fault[2] = 2'd0; en = 1'b0;
    for (int i = 0; i < 5; i++) step();
    chk(st == S_LAT && !req, "R9 latch ignores enable", int'(st), 4);
    en = 1'b1;
    step();
    chk(st == S_LAT, "R9 latch ignores reenable", int'(st), 4);
    do_reset();
    chk(st == S_OFF, "R9 reset clears latch", int'(st), 0);

    // bus error in regulate
    go_reg(6'd2, 8'd1, 3'd2);
    berr = 1'b1;
    step();
    berr = 1'b0;
    chk(st == S_LAT && !pg, "R7 bus error latches", int'(st), 4);

    // response timeout
    go_reg(6'd2, 8'd1, 3'd3);
    for (int i = 0; i < 20 && req; i++) step();
    auto_rsp = 1'b0;
    step();
    chk(req == 1'b1, "R4 new request raised", int'(req), 1);
    for (int i = 0; i < 63; i++) step();
    chk(st == S_REG && req, "R8 no timeout at 63", int'(st), 2);
    step();
    chk(st == S_LAT, "R8 timeout at 64", int'(st), 4);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule